// File: doc/BRIEF.md
# Receive-Command Status Event Generator

This block sits on the PHY side of a ULPI link. It watches the USB line state, three VBUS comparator outputs, the ID pin level and a host-disconnect comparator. From these it builds 8-bit receive-command status bytes. Each status change produces one byte, which waits in a short queue until the bus arbiter grants the shared data bus. The byte is then presented for one cycle and removed.

Disconnect detection works only in high-speed host mode. The host start-of-frame end-of-packet delimiter is 40 bit times long. A bit-time counter follows it and reads the comparator only in bit times 32 to 36. A high reading inside that window means the device terminations are gone, so the block sets a disconnect flag. A window with only low readings clears the flag. Every change of the flag queues a byte, so the event stays queued while the bus is busy.

Rise and fall enables select which transitions of the disconnect flag, VBUS-valid and session-end produce a byte. The enables come out of reset fully set. Clearing the comparator enables during suspend silences those comparators.

Top module: `rxcmd_gen`

## Requirements
- R1: The disconnect flag is held low whenever `hs_host` is low, and it drops in the cycle after `hs_host` falls.
- R2: The bit-time counter counts `bit_tick` pulses after an `eop_start` pulse. The first tick is bit 0. `disc_cmp` is read only in bits 32 to 36 of the 40-bit delimiter. A high reading in any other bit has no effect.
- R3: A high reading inside the window sets the disconnect flag at bit 36. A window with only low readings clears the flag.
- R4: A change of the disconnect flag queues one byte carrying the new flag value. By default this needs no enable write.
- R5: Byte layout: bits 1:0 are the line state and bits 3:2 are the VBUS code. Bits 5:4 are the receive event: 00 none, 01 receive active, 10 host disconnect. Bit 6 is the ID level and bit 7 is 0. A change of line state, ID or session-valid always queues a byte, and that byte is visible in the cycle after the change is sampled.
- R6: VBUS code: 11 when VBUS-valid is set, else 10 when session-valid is set, else 00 when session-end is set, else 01.
- R7: A byte built while `rx_active` is high carries event 01, never 10. No byte is presented while `rx_active` is high.
- R8: Bits [0], [1] and [2] of the rise and fall enables select the disconnect flag, VBUS-valid and session-end. All enables reset to 1. A transition whose enable is 0 queues no byte.
- R9: A queued byte is presented only while `bus_grant` is high. It is removed at the end of the cycle in which it is presented.
- R10: The queue holds 2 bytes. A new event that arrives while the queue is full replaces the newest entry and keeps the oldest.
- R11: After reset nothing is queued. Inputs that stay steady through reset and the first cycle after it produce no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_host | input | 1 | High when configured as high-speed host |
| eop_start | input | 1 | Pulse marking the start of an SOF end-of-packet delimiter |
| bit_tick | input | 1 | One pulse per high-speed bit time of the delimiter |
| disc_cmp | input | 1 | Disconnect amplitude comparator output |
| line_state | input | 2 | Current line state |
| sess_end | input | 1 | Session-end comparator |
| sess_valid | input | 1 | Session-valid comparator |
| vbus_valid | input | 1 | VBUS-valid comparator |
| id_level | input | 1 | ID pin level |
| rx_active | input | 1 | Packet reception in progress |
| cfg_we | input | 1 | Load the edge enables |
| cfg_rise_en | input | 3 | Rising-edge enables (disconnect, VBUS-valid, session-end) |
| cfg_fall_en | input | 3 | Falling-edge enables (same order) |
| bus_grant | input | 1 | Data bus granted to status traffic |
| rxcmd_valid | output | 1 | Status byte presented this cycle |
| rxcmd_byte | output | 8 | Presented status byte |

## Verification
A level change applied before a clock edge is registered at that edge, and with the grant high its byte is on the output right after the same edge. The bench therefore drives inputs at the falling edge and samples just after the next rising edge. It then checks one edge later that the byte has gone. For a disconnect, the flag is set at the edge of bit 36 and the byte is queued one edge later. The bench keeps the grant low through the delimiter and raises it afterwards. It reads the queue combinationally, so the check does not depend on that exact edge. Tests for ignored edges and for overwrite use two quiet cycles, or they drain the queue in order to expose what it holds.

// File: rtl/rxcmd_pkg.sv
package rxcmd_pkg;

   localparam int NSRC     = 3;
   localparam int SRC_DISC = 0;
   localparam int SRC_VBUS = 1;
   localparam int SRC_SEND = 2;

   typedef enum logic [1:0] {
      EV_NONE  = 2'b00,
      EV_RXACT = 2'b01,
      EV_DISC  = 2'b10
   } rx_ev_e;

   typedef struct packed {
      logic       zero;
      logic       id;
      rx_ev_e     ev;
      logic [1:0] vbus;
      logic [1:0] ls;
   } status_t;

   function automatic logic [1:0] vbus_code(input logic vv, input logic sv, input logic se);
      if (vv)      return 2'b11;
      else if (sv) return 2'b10;
      else if (se) return 2'b00;
      else         return 2'b01;
   endfunction

endpackage

// File: rtl/rxcmd_disc_det.sv
module rxcmd_disc_det #(
   parameter int EOP_BITS = 40,
   parameter int WIN_LO   = 32,
   parameter int WIN_HI   = 36
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hs_host,
   input  logic eop_start,
   input  logic bit_tick,
   input  logic cmp,
   output logic disc
);
   localparam int CW = $clog2(EOP_BITS);
   localparam logic [CW-1:0] LAST_C = CW'(EOP_BITS - 1);
   localparam logic [CW-1:0] LO_C   = CW'(WIN_LO);
   localparam logic [CW-1:0] HI_C   = CW'(WIN_HI);

   logic          active_q;
   logic          hit_q;
   logic [CW-1:0] cnt_q;
   logic          in_win;

   assign in_win = (cnt_q >= LO_C) && (cnt_q <= HI_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         hit_q    <= 1'b0;
         cnt_q    <= '0;
         disc     <= 1'b0;
      end else if (!hs_host) begin
         active_q <= 1'b0;
         hit_q    <= 1'b0;
         cnt_q    <= '0;
         disc     <= 1'b0;
      end else if (eop_start) begin
         active_q <= 1'b1;
         hit_q    <= 1'b0;
         cnt_q    <= '0;
      end else if (active_q && bit_tick) begin
         if (cnt_q == HI_C) begin
            disc  <= hit_q | cmp;
            hit_q <= 1'b0;
         end else if (in_win && cmp) begin
            hit_q <= 1'b1;
         end
         if (cnt_q == LAST_C) active_q <= 1'b0;
         else                 cnt_q    <= cnt_q + 1'b1;
      end
   end

   // R1
   dev_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hs_host |=> !disc);

   // R2
   disc_change_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((disc != $past(disc)) && $past(hs_host)) |->
         $past(active_q && bit_tick && !eop_start && cnt_q == HI_C));

endmodule

// File: rtl/rxcmd_evt.sv
module rxcmd_evt
   import rxcmd_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      line_state,
   input  logic            sess_end,
   input  logic            sess_valid,
   input  logic            vbus_valid,
   input  logic            id_level,
   input  logic            disc,
   input  logic            rx_active,
   input  logic            cfg_we,
   input  logic [NSRC-1:0] cfg_rise_en,
   input  logic [NSRC-1:0] cfg_fall_en,
   output logic            push,
   output status_t         push_byte
);
   logic [NSRC-1:0] rise_en_q, fall_en_q;
   logic [NSRC-1:0] src_cur, src_prev_q, src_evt;
   logic [1:0]      ls_prev_q;
   logic            id_prev_q, sv_prev_q, primed_q;
   logic            level_chg;

   assign src_cur[SRC_DISC] = disc;
   assign src_cur[SRC_VBUS] = vbus_valid;
   assign src_cur[SRC_SEND] = sess_end;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign src_evt[i] = (src_cur[i] & ~src_prev_q[i] & rise_en_q[i]) |
                          (~src_cur[i] & src_prev_q[i] & fall_en_q[i]);
   end

   assign level_chg = (line_state != ls_prev_q) || (id_level != id_prev_q) ||
                      (sess_valid != sv_prev_q);
   assign push      = primed_q && (level_chg || (|src_evt));

   always_comb begin
      push_byte.zero = 1'b0;
      push_byte.id   = id_level;
      push_byte.vbus = vbus_code(vbus_valid, sess_valid, sess_end);
      push_byte.ls   = line_state;
      if (rx_active)  push_byte.ev = EV_RXACT;
      else if (disc)  push_byte.ev = EV_DISC;
      else            push_byte.ev = EV_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_en_q  <= '1;
         fall_en_q  <= '1;
         src_prev_q <= '0;
         ls_prev_q  <= '0;
         id_prev_q  <= 1'b0;
         sv_prev_q  <= 1'b0;
         primed_q   <= 1'b0;
      end else begin
         if (cfg_we) begin
            rise_en_q <= cfg_rise_en;
            fall_en_q <= cfg_fall_en;
         end
         src_prev_q <= src_cur;
         ls_prev_q  <= line_state;
         id_prev_q  <= id_level;
         sv_prev_q  <= sess_valid;
         primed_q   <= 1'b1;
      end
   end

   // R11
   first_cycle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !primed_q |-> !push);

endmodule

// File: rtl/rxcmd_fifo.sv
module rxcmd_fifo #(
   parameter int DEPTH = 2,
   parameter int W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] rd_q, wr_idx;
   logic [CW-1:0] cnt_q;
   logic          full, do_wr_new;

   function automatic logic [PW-1:0] wrap(input logic [PW-1:0] base, input int off);
      int s;
      s = int'(base) + off;
      if (s >= DEPTH) s = s - DEPTH;
      return PW'(s);
   endfunction

   assign full      = (cnt_q == FULL_C);
   assign empty     = (cnt_q == '0);
   assign dout      = mem[rd_q];
   assign do_wr_new = push && (pop || !full);

   always_comb begin
      if (pop || !full) wr_idx = wrap(rd_q, int'(cnt_q));
      else              wr_idx = wrap(rd_q, int'(cnt_q) - 1);
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         mem[i] <= '0;
         else if (push && wr_idx == PW'(i))  mem[i] <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (pop) rd_q <= wrap(rd_q, 1);
         cnt_q <= cnt_q + CW'(do_wr_new) - CW'(pop);
      end
   end

   // R10
   // no_overflow_chk: the count never passes the depth
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL_C);

   // R9
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

   // R10
   overwrite_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> full);

endmodule

// File: rtl/rxcmd_gen.sv
module rxcmd_gen
   import rxcmd_pkg::*;
#(
   parameter int EOP_BITS = 40,
   parameter int WIN_LO   = 32,
   parameter int WIN_HI   = 36,
   parameter int DEPTH    = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hs_host,
   input  logic       eop_start,
   input  logic       bit_tick,
   input  logic       disc_cmp,
   input  logic [1:0] line_state,
   input  logic       sess_end,
   input  logic       sess_valid,
   input  logic       vbus_valid,
   input  logic       id_level,
   input  logic       rx_active,
   input  logic       cfg_we,
   input  logic [2:0] cfg_rise_en,
   input  logic [2:0] cfg_fall_en,
   input  logic       bus_grant,
   output logic       rxcmd_valid,
   output logic [7:0] rxcmd_byte
);
   if (WIN_LO > WIN_HI || WIN_HI >= EOP_BITS) begin : g_bad_window
      $error("rxcmd_gen: sampling window must lie inside the delimiter");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("rxcmd_gen: queue depth must be at least 1");
   end

   logic    disc, push, q_empty;
   status_t push_byte;

   rxcmd_disc_det #(.EOP_BITS(EOP_BITS), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_disc (
      .clk(clk), .rst_n(rst_n), .hs_host(hs_host), .eop_start(eop_start),
      .bit_tick(bit_tick), .cmp(disc_cmp), .disc(disc));

   rxcmd_evt u_evt (
      .clk(clk), .rst_n(rst_n), .line_state(line_state), .sess_end(sess_end),
      .sess_valid(sess_valid), .vbus_valid(vbus_valid), .id_level(id_level),
      .disc(disc), .rx_active(rx_active), .cfg_we(cfg_we),
      .cfg_rise_en(cfg_rise_en), .cfg_fall_en(cfg_fall_en),
      .push(push), .push_byte(push_byte));

   rxcmd_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .din(push_byte),
      .pop(rxcmd_valid), .dout(rxcmd_byte), .empty(q_empty));

   assign rxcmd_valid = !q_empty && bus_grant && !rx_active;

   // R7
   rx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && rx_active) |-> (push_byte.ev != EV_DISC));

   // R5
   top_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rxcmd_valid |-> !rxcmd_byte[7]);

endmodule

// File: tb/rxcmd_gen_tb.sv
`timescale 1ns/1ps
module rxcmd_gen_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hs_host = 1'b1, eop_start = 1'b0, bit_tick = 1'b0, disc_cmp = 1'b0;
   logic [1:0] line_state = 2'b01;
   logic       sess_end = 1'b1, sess_valid = 1'b0, vbus_valid = 1'b0, id_level = 1'b1;
   logic       rx_active = 1'b0, cfg_we = 1'b0, bus_grant = 1'b1;
   logic [2:0] cfg_rise_en = 3'b111, cfg_fall_en = 3'b111;
   logic       rxcmd_valid;
   logic [7:0] rxcmd_byte;
   int         n_chk = 0, n_fail = 0, cyc = 0;

   always #5 clk = ~clk;

   rxcmd_gen u_dut (.*);

   // {line_state, sess_end, sess_valid, vbus_valid, id_level, expected byte}
   localparam logic [13:0] VEC [8] = '{
      {2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 8'h40},
      {2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h44},
      {2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 8'h48},
      {2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 8'h4C},
      {2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 8'h4E},
      {2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 8'h0E},
      {2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 8'h0D},
      {2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 8'h09}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=<20000", cyc);
         finish_run();
      end
   end

   // expect one byte now, gone one edge later
   task automatic expect_one(input string req, input logic [7:0] exp);
      chk(req, {7'd0, rxcmd_valid}, 8'd1);
      chk(req, rxcmd_byte, exp);
      @(posedge clk); #1;
      chk(req, {7'd0, rxcmd_valid}, 8'd0);
   endtask

   task automatic quiet2(input string req);
      for (int k = 0; k < 2; k++) begin
         @(posedge clk); #1;
         chk(req, {7'd0, rxcmd_valid}, 8'd0);
      end
   endtask

   // one delimiter; comparator high from bit lo to bit hi
   task automatic run_eop(input int lo, input int hi);
      @(negedge clk); bus_grant = 1'b0; eop_start = 1'b1;
      @(negedge clk); eop_start = 1'b0;
      for (int b = 0; b < 40; b++) begin
         bit_tick = 1'b1;
         disc_cmp = (b >= lo && b <= hi);
         @(negedge clk);
      end
      bit_tick = 1'b0; disc_cmp = 1'b0;
      @(negedge clk); @(negedge clk);
   endtask

   task automatic grant_and_expect(input string req, input logic [7:0] exp);
      bus_grant = 1'b1; #1;
      expect_one(req, exp);
   endtask

   task automatic grant_and_none(input string req);
      bus_grant = 1'b1; #1;
      chk(req, {7'd0, rxcmd_valid}, 8'd0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R11: steady inputs after reset give nothing
      quiet2("R11");

      // R5 R6: table of level changes
      for (int v = 0; v < 8; v++) begin
         @(negedge clk);
         {line_state, sess_end, sess_valid, vbus_valid, id_level} = VEC[v][13:8];
         @(posedge clk); #1;
         expect_one("R5_R6", VEC[v][7:0]);
      end

      // R9: held while grant low
      @(negedge clk); bus_grant = 1'b0; line_state = 2'b10;
      quiet2("R9");
      @(negedge clk); grant_and_expect("R9", 8'h0A);
      @(negedge clk); line_state = 2'b01; @(posedge clk); #1;
      expect_one("R9", 8'h09);

      // R2: high outside the window does nothing
      run_eop(31, 31); grant_and_none("R2");
      run_eop(37, 39); grant_and_none("R2");
      // R3 R4: high inside window sets the flag, default enables
      run_eop(34, 34); grant_and_expect("R3_R4", 8'h29);

      // R7: byte built during receive carries event 01, held while rx active
      @(negedge clk); rx_active = 1'b1; line_state = 2'b10;
      @(posedge clk); #1; chk("R7", {7'd0, rxcmd_valid}, 8'd0);
      @(negedge clk); rx_active = 1'b0; #1; expect_one("R7", 8'h1A);
      @(negedge clk); line_state = 2'b01; @(posedge clk); #1;
      expect_one("R7", 8'h29);

      // R3: all-low window clears the flag
      run_eop(99, 99); grant_and_expect("R3", 8'h09);
      // R1: device mode ignores comparator
      @(negedge clk); hs_host = 1'b0;
      run_eop(32, 36); grant_and_none("R1");
      // R1: leaving host mode clears the flag
      @(negedge clk); hs_host = 1'b1;
      run_eop(36, 36); grant_and_expect("R1", 8'h29);
      @(negedge clk); bus_grant = 1'b0; hs_host = 1'b0;
      @(negedge clk); @(negedge clk); grant_and_expect("R1", 8'h09);

      // R8: masked comparator edges
      @(negedge clk); cfg_we = 1'b1; cfg_rise_en = 3'b001; cfg_fall_en = 3'b001;
      @(negedge clk); cfg_we = 1'b0; vbus_valid = 1'b1;
      quiet2("R8");
      @(negedge clk); sess_end = 1'b1;
      quiet2("R8");
      @(negedge clk); sess_end = 1'b0;
      quiet2("R8");
      @(negedge clk); line_state = 2'b00; @(posedge clk); #1;
      expect_one("R8", 8'h0C);
      @(negedge clk); cfg_we = 1'b1; cfg_rise_en = 3'b111; cfg_fall_en = 3'b111;
      @(negedge clk); cfg_we = 1'b0; vbus_valid = 1'b0; @(posedge clk); #1;
      expect_one("R8", 8'h08);

      // R10: third event overwrites newest
      @(negedge clk); bus_grant = 1'b0; line_state = 2'b01;
      @(negedge clk); line_state = 2'b10;
      @(negedge clk); line_state = 2'b11;
      @(negedge clk); bus_grant = 1'b1; #1;
      chk("R10", rxcmd_byte, 8'h09);
      @(posedge clk); #1; chk("R10", rxcmd_byte, 8'h0B);
      chk("R10", {7'd0, rxcmd_valid}, 8'd1);
      @(posedge clk); #1; chk("R10", {7'd0, rxcmd_valid}, 8'd0);

      finish_run();
   end
endmodule